// File: doc/BRIEF.md
# Word-Serial Carry-Less Polynomial Multiplier

This block multiplies two binary polynomials of 163 coefficients each and returns their full product without any modular reduction. It works word-serially. Each operand is split into six 32-bit words, and the most significant word carries only three live bits above zero padding. A single 32x32 carry-less multiplier forms one word-pair product per clock.

The products are gathered column by column over the output words into a two-word XOR accumulator. Each finished column writes its low accumulator word into the product. The high accumulator word then moves down into the low word, and the high word is cleared.

A caller presents both operands with a one-cycle `start` pulse. It then waits while `busy` is high and collects the twelve-word product when `done` pulses. The result stays on `product` until the next accepted start.

Top module: `polymul_serial`

## Requirements
- R1: When `done` is high, `product` equals the carry-less (AND-XOR) product of the two operands latched at start. Bit n of `product` is the XOR over all i+k=n of `opA[i]&opB[k]`, and word 0 (bits 31:0) is the least significant word.
- R2: When `done` is high, every `product` bit from 325 up to 383 is zero.
- R3: The operands are captured on the clock edge that accepts `start`. Later changes on `opA`/`opB` do not alter the product being computed.
- R4: A `start` pulse that arrives while `busy` is high is ignored. The running multiplication neither restarts nor changes its result or latency.
- R5: `busy` goes high on the edge that accepts `start` (while idle). It stays high for exactly 48 cycles: 36 word-multiply cycles, 11 column-shift cycles and one final-word cycle.
- R6: `done` is a single-cycle pulse. It is asserted in the first cycle in which `busy` is low again.
- R7: While idle with no `start`, `product` holds its value.
- R8: After reset, `busy`, `done` and the whole of `product` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a multiplication (accepted only while idle) |
| opA | input | 163 | First polynomial operand |
| opB | input | 163 | Second polynomial operand |
| busy | output | 1 | Multiplication in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 384 | Twelve-word unreduced product, word 0 lowest |

## Verification
The assertions take for granted that `start` is only expected to take effect while the block is idle. They also assume the operand ports are 163 bits wide, so the padding bits of the top word are always zero. The stimulus keeps to this by holding `start` for exactly one cycle from idle, except for a deliberate pulse during a busy run. That pulse checks that the run is unaffected. Expected products come from a bit-level shift-and-XOR loop over a sweep of single-bit operand pairs, all-zero, all-one and random operands.

// File: rtl/polymul_pkg.sv
package polymul_pkg;
  localparam int IDX_W = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MAC   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_FINAL = 2'd3
  } ctrlState_t;

  typedef struct packed {
    logic             loadOps;
    logic             mac;
    logic             shift;
    logic             fin;
    logic [IDX_W-1:0] aIdx;
    logic [IDX_W-1:0] bIdx;
    logic [IDX_W-1:0] col;
  } dpStrobe_t;
endpackage

// File: rtl/polymul_clmul.sv
module polymul_clmul #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]   wa,
  input  logic [WORD_W-1:0]   wb,
  output logic [2*WORD_W-1:0] wp
);
  always_comb begin
    wp = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (wb[i]) wp = wp ^ ({{WORD_W{1'b0}}, wa} << i);
    end
  end
endmodule

// File: rtl/polymul_ctrl.sv
module polymul_ctrl
  import polymul_pkg::*;
#(
  parameter int NUM_WORDS = 6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  output logic      busy,
  output logic      done,
  output dpStrobe_t stb
);
  localparam logic [IDX_W-1:0] LAST_WORD = IDX_W'(NUM_WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_COL  = IDX_W'(2 * NUM_WORDS - 2);

  ctrlState_t       state;
  logic [IDX_W-1:0] col, jCur, jHi, nextCol, jLoNext;

  assign jHi     = (col < IDX_W'(NUM_WORDS)) ? col : LAST_WORD;
  assign nextCol = col + 1'b1;
  assign jLoNext = (nextCol < IDX_W'(NUM_WORDS)) ? '0 : nextCol - LAST_WORD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      col   <= '0;
      jCur  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_MAC;
          col   <= '0;
          jCur  <= '0;
        end
        ST_MAC: begin
          if (jCur == jHi) state <= ST_SHIFT;
          else             jCur  <= jCur + 1'b1;
        end
        ST_SHIFT: begin
          if (col == LAST_COL) state <= ST_FINAL;
          else begin
            state <= ST_MAC;
            col   <= nextCol;
            jCur  <= jLoNext;
          end
        end
        ST_FINAL: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    stb         = '0;
    stb.loadOps = (state == ST_IDLE) && start;
    stb.mac     = (state == ST_MAC);
    stb.shift   = (state == ST_SHIFT);
    stb.fin     = (state == ST_FINAL);
    stb.aIdx    = jCur;
    stb.bIdx    = col - jCur;
    stb.col     = col;
  end
endmodule

// File: rtl/polymul_dp.sv
module polymul_dp
  import polymul_pkg::*;
#(
  parameter int OPER_W    = 163,
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  dpStrobe_t                     stb,
  input  logic [OPER_W-1:0]             opA,
  input  logic [OPER_W-1:0]             opB,
  output logic [2*NUM_WORDS*WORD_W-1:0] product
);
  localparam int PAD_W = NUM_WORDS * WORD_W;
  localparam int OUT_W = 2 * PAD_W;

  logic [PAD_W-1:0]    regA, regB;
  logic [WORD_W-1:0]   accHi, accLo, wordA, wordB;
  logic [2*WORD_W-1:0] wordProd;
  logic [OUT_W-1:0]    zReg;

  assign wordA = regA[stb.aIdx*WORD_W +: WORD_W];
  assign wordB = regB[stb.bIdx*WORD_W +: WORD_W];

  polymul_clmul #(.WORD_W(WORD_W)) u_clmul (
    .wa(wordA),
    .wb(wordB),
    .wp(wordProd)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regA  <= '0;
      regB  <= '0;
      accHi <= '0;
      accLo <= '0;
      zReg  <= '0;
    end else if (stb.loadOps) begin
      regA  <= PAD_W'(opA);
      regB  <= PAD_W'(opB);
      accHi <= '0;
      accLo <= '0;
      zReg  <= '0;
    end else if (stb.mac) begin
      accHi <= accHi ^ wordProd[2*WORD_W-1:WORD_W];
      accLo <= accLo ^ wordProd[WORD_W-1:0];
    end else if (stb.shift) begin
      zReg[stb.col*WORD_W +: WORD_W] <= accLo;
      accLo <= accHi;
      accHi <= '0;
    end else if (stb.fin) begin
      zReg[OUT_W-1 -: WORD_W] <= accLo;
    end
  end

  assign product = zReg;
endmodule

// File: rtl/polymul_serial.sv
module polymul_serial
  import polymul_pkg::*;
#(
  parameter int OPER_W    = 163,
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = (OPER_W + WORD_W - 1) / WORD_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [OPER_W-1:0]             opA,
  input  logic [OPER_W-1:0]             opB,
  output logic                          busy,
  output logic                          done,
  output logic [2*NUM_WORDS*WORD_W-1:0] product
);
  dpStrobe_t stb;

  polymul_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .busy(busy), .done(done), .stb(stb)
  );

  polymul_dp #(.OPER_W(OPER_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .opA(opA), .opB(opB), .product(product)
  );
endmodule

// File: rtl/polymul_serial_chk.sv
module polymul_serial_chk #(
  parameter int OPER_W    = 163,
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 6
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          start,
  input logic                          busy,
  input logic                          done,
  input logic [2*NUM_WORDS*WORD_W-1:0] product
);
  localparam int OUT_W   = 2 * NUM_WORDS * WORD_W;
  localparam int SIG_W   = 2 * OPER_W - 1;
  localparam int LATENCY = NUM_WORDS * NUM_WORDS + 2 * NUM_WORDS;

  logic [15:0] busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                busyCnt <= '0;
    else if (!busy && start)  busyCnt <= '0;
    else if (busy)            busyCnt <= busyCnt + 1'b1;
  end

  AST_ZERO_ABOVE_SIG: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (product[OUT_W-1:SIG_W] == '0)); // R2
  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> busy); // R5
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyCnt == 16'(LATENCY))); // R5
  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && busyCnt < 16'(LATENCY - 1)) |=> busy); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R6
  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product)); // R7
endmodule

bind polymul_serial polymul_serial_chk #(
  .OPER_W(OPER_W), .WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start),
  .busy(busy), .done(done), .product(product)
);

// File: tb/polymul_serial_tb.sv
module polymul_serial_tb;
  localparam int OPER_W = 163;
  localparam int OUT_W  = 384;
  localparam int LAT    = 48;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [OPER_W-1:0] opA = '0, opB = '0;
  logic              busy, done;
  logic [OUT_W-1:0]  product;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  polymul_serial u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [OUT_W-1:0] refMul(input logic [OPER_W-1:0] a, input logic [OPER_W-1:0] b);
    logic [OUT_W-1:0] acc = '0;
    for (int k = 0; k < OPER_W; k++)
      if (b[k]) acc = acc ^ (OUT_W'(a) << k);
    return acc;
  endfunction

  function automatic logic [OPER_W-1:0] rndOp();
    logic [191:0] r;
    for (int k = 0; k < 6; k++) r[k*32 +: 32] = $urandom;
    return r[OPER_W-1:0];
  endfunction

  task automatic check(input string req, input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One multiplication; disturb=1 changes operands and pulses start mid-run (R3, R4)
  task automatic runMul(input logic [OPER_W-1:0] a, input logic [OPER_W-1:0] b, input bit disturb);
    logic [OUT_W-1:0] exp;
    int cyc;
    exp = refMul(a, b);
    @(negedge clk);
    opA = a; opB = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R5 busy after start", OUT_W'(busy), OUT_W'(1));
    cyc = 0;
    while (!done && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (disturb && cyc == 7) begin
        opA = ~a; opB = rndOp(); start = 1'b1;
      end else if (disturb && cyc == 8) begin
        start = 1'b0;
      end
    end
    check(disturb ? "R1 R3 R4 product under disturbance" : "R1 product", product, exp);
    check("R2 upper bits zero", OUT_W'(product[OUT_W-1:325]), '0);
    check(disturb ? "R4 R5 latency" : "R5 latency", OUT_W'(cyc), OUT_W'(LAT));
    check("R6 done with busy low", OUT_W'(busy), '0);
    @(negedge clk);
    check("R6 done single cycle", OUT_W'(done), '0);
  endtask

  initial begin
    logic [OUT_W-1:0] held;
    #200000;
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [OUT_W-1:0] held;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 reset busy", OUT_W'(busy), '0);
    check("R8 reset done", OUT_W'(done), '0);
    check("R8 reset product", product, '0);

    runMul('0, '0, 0);
    runMul('1, '1, 0);
    runMul(OPER_W'(1), OPER_W'(1), 0);
    runMul(OPER_W'(1) << 162, OPER_W'(1) << 162, 0);
    runMul(OPER_W'(1), OPER_W'(1) << 162, 0);
    runMul('1, OPER_W'(1) << 162, 0);
    for (int i = 0; i < OPER_W; i += 9)
      for (int k = 0; k < OPER_W; k += 13)
        runMul(OPER_W'(1) << i, OPER_W'(1) << k, 0);
    for (int n = 0; n < 20; n++) runMul(rndOp(), rndOp(), 0);
    runMul(rndOp(), rndOp(), 1);
    runMul('1, '1, 1);

    // R7: idle with changing inputs, no start
    held = product;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      opA = rndOp(); opB = rndOp();
    end
    check("R7 product held while idle", product, held);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule